// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests from five sources: two active-low external pins, two timer overflow pulses and one serial-port request. It keeps a pending flag for each one. Once per machine cycle it decides whether the CPU must take a hardware call to a vector address. Each source has its own enable bit and its own priority bit, and one global enable gates all five. The controller remembers which of the two priority levels is currently in service, and a return-from-interrupt pulse from the CPU releases a level.

The CPU drives `cyc_end` high for one clock in the final state of every machine cycle. On that edge the controller stores a snapshot of the pending flags. On the next strobe it polls that snapshot, if the CPU reports that the current cycle ends an instruction and that the instruction is neither a return nor a write to the enable or priority settings. A winning poll produces a one-clock `vec_req` pulse with the vector address. The CPU then pushes its program counter and jumps to that address. Source index n (external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4) maps to the vector address 3 + 8·n.

Top module: `irq_vec2`

## Requirements
- R1: After reset, `flags`, `in_svc` and `vec_req` are all zero.
- R2: An external pin in edge mode (`ext_lvl` bit 0) sets its flag on a high-to-low transition. A timer pulse sets flag bit 1 (timer 0) or bit 3 (timer 1). `ser_req` sets flag bit 4. External 0 drives flag bit 0 and external 1 drives flag bit 2.
- R3: An external pin in level mode (`ext_lvl` bit 1) sets its flag on every clock the pin is low. A software clear of that flag takes effect only once the pin is high.
- R4: A pending flag vectors only if both its `src_en` bit and `gen` are 1. A masked flag stays pending and is vectored once it is unmasked.
- R5: Among the eligible requests, the high level (`pri` bit 1) wins over the low level. Within one level the lowest source index wins.
- R6: A poll uses the flags stored at the previous `cyc_end` strobe. When a flag is set before strobe A and strobe B follows A, `vec_req` is 1 for exactly the one clock after B and `vec_addr` = 3 + 8·n at that clock. The clock after strobe A shows no `vec_req`.
- R7: A poll is blocked when `last_cyc` is 0 or `blk_instr` is 1. A blocked request is not remembered: if the flag is cleared before a later snapshot, that request never vectors.
- R8: Vectoring sets the in-service bit of the winning level (`in_svc` bit 1 = high, bit 0 = low). While the high bit is set, nothing vectors. While only the low bit is set, only high-level requests vector.
- R9: On vectoring, hardware clears the winner's flag if the winner is a timer or an edge-mode external. A level-mode external flag and the serial flag stay set.
- R10: A `reti` pulse clears `in_svc` bit 1 if that bit is set, and otherwise clears bit 0.
- R11: A `flag_clr` bit clears the matching flag. If a set event arrives in the same clock, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_end | input | 1 | One-clock strobe in the final state of each machine cycle |
| last_cyc | input | 1 | The current machine cycle is the last one of the executing instruction |
| blk_instr | input | 1 | The executing instruction is a return or a write to the enable or priority settings |
| ext_n | input | 2 | External request pins, active low |
| ext_lvl | input | 2 | Per-pin trigger mode: 1 = low level, 0 = falling edge |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_req | input | 1 | Serial-port request |
| flag_clr | input | 5 | Software clear, one bit per flag |
| src_en | input | 5 | Per-source enable |
| gen | input | 1 | Global enable |
| pri | input | 5 | Per-source priority level: 1 = high |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_req | output | 1 | One-clock hardware-call request |
| vec_addr | output | 16 | Vector address, valid while `vec_req` is 1 |
| flags | output | 5 | Pending flags |
| in_svc | output | 2 | In-service levels: bit 1 = high, bit 0 = low |

## Verification
The main sweep raises every one of the 32 combinations of pending sources, each under all 32 priority settings. For each case it checks the chosen vector against a level-then-index arbitration computed in the bench, and checks which flags survive. This separates level priority from polling order and shows which flags hardware clears. Directed sequences cover the rest:
- level-mode pins held low across a software clear;
- masking through each enable, followed by release;
- polls blocked by a non-final cycle and by a blocking instruction, with the flag cleared before the next snapshot;
- a low-level routine preempted by a high-level request, with the release order on return.

// File: rtl/irq_vec2.sv
module irq_vec2 #(
  parameter int AW    = 16,
  parameter int VBASE = 3,
  parameter int VSTEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_end,
  input  logic          last_cyc,
  input  logic          blk_instr,
  input  logic [1:0]    ext_n,
  input  logic [1:0]    ext_lvl,
  input  logic [1:0]    tmr_ovf,
  input  logic          ser_req,
  input  logic [4:0]    flag_clr,
  input  logic [4:0]    src_en,
  input  logic          gen,
  input  logic [4:0]    pri,
  input  logic          reti,
  output logic          vec_req,
  output logic [AW-1:0] vec_addr,
  output logic [4:0]    flags,
  output logic [1:0]    in_svc
);
  logic [1:0] ext_q;
  logic [4:0] snap;
  logic [4:0] req_hi, req_lo, cand, grant, clr_v, set_v, hwc, flags_nxt;
  logic [2:0] idx;
  logic       use_hi, poll_ok, go;
  logic [1:0] svc_nxt;

  wire [1:0] ext_fall = ext_q & ~ext_n;
  wire [1:0] ext_set  = (ext_lvl & ~ext_n) | (~ext_lvl & ext_fall);

  assign set_v = {ser_req, tmr_ovf[1], ext_set[1], tmr_ovf[0], ext_set[0]};
  assign hwc   = {1'b0, 1'b1, ~ext_lvl[1], 1'b1, ~ext_lvl[0]};

  assign req_hi  = snap & src_en & pri;
  assign req_lo  = snap & src_en & ~pri;
  assign use_hi  = |req_hi;
  assign cand    = use_hi ? req_hi : (in_svc[0] ? 5'b0 : req_lo);
  assign poll_ok = cyc_end & last_cyc & ~blk_instr & gen & ~in_svc[1];
  assign go      = poll_ok & (|cand);

  always_comb begin
    idx = 3'd0;
    for (int i = 4; i >= 0; i--)
      if (cand[i]) idx = 3'(i);
  end

  assign grant     = 5'b00001 << idx;
  assign clr_v     = (go ? (grant & hwc) : 5'b0) | flag_clr;
  assign flags_nxt = (flags & ~clr_v) | set_v;

  always_comb begin
    svc_nxt = in_svc;
    if (reti) begin
      if (in_svc[1]) svc_nxt[1] = 1'b0;
      else           svc_nxt[0] = 1'b0;
    end
    if (go) begin
      if (use_hi) svc_nxt[1] = 1'b1;
      else        svc_nxt[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q    <= 2'b11;
      flags    <= '0;
      snap     <= '0;
      in_svc   <= '0;
      vec_req  <= 1'b0;
      vec_addr <= '0;
    end else begin
      ext_q   <= ext_n;
      flags   <= flags_nxt;
      in_svc  <= svc_nxt;
      vec_req <= go;
      if (cyc_end) snap <= flags_nxt;
      if (go) vec_addr <= AW'(VBASE + VSTEP * int'(idx));
    end
  end
endmodule

module irq_vec2_chk #(
  parameter int AW    = 16,
  parameter int VBASE = 3,
  parameter int VSTEP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_end,
  input logic          last_cyc,
  input logic          blk_instr,
  input logic          gen,
  input logic          reti,
  input logic [1:0]    tmr_ovf,
  input logic          vec_req,
  input logic [AW-1:0] vec_addr,
  input logic [4:0]    flags,
  input logic [1:0]    in_svc
);
  // R6
  vec_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(cyc_end));
  // R7
  vec_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(last_cyc && !blk_instr && gen));
  // R8
  no_vec_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !$past(in_svc[1]));
  // R8
  svc_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (in_svc != 2'b00));
  // R6
  vec_addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ((32'(vec_addr) >= VBASE) && ((32'(vec_addr) - VBASE) % VSTEP == 0)
                 && (32'(vec_addr) <= VBASE + 4 * VSTEP)));
  // R10
  reti_high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_svc[1]) |=> !in_svc[1]);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf[0] |=> flags[1]);
endmodule

bind irq_vec2 irq_vec2_chk #(.AW(AW), .VBASE(VBASE), .VSTEP(VSTEP)) chk (.*);

// File: tb/tb_irq_vec2.sv
`timescale 1ns/1ps
module tb_irq_vec2;
  logic clk = 0, rst_n = 0;
  logic cyc_end = 0, last_cyc = 0, blk_instr = 0, ser_req = 0, gen = 0, reti = 0;
  logic [1:0] ext_n = 2'b11, ext_lvl = 2'b00, tmr_ovf = 2'b00, in_svc;
  logic [4:0] flag_clr = 0, src_en = 0, pri = 0, flags;
  logic vec_req;
  logic [15:0] vec_addr;
  int nchk = 0, nfail = 0;

  irq_vec2 dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input bit lc);
    @(negedge clk) begin cyc_end = 1; last_cyc = lc; end
    @(negedge clk) begin cyc_end = 0; last_cyc = 0; end
  endtask

  task automatic raise(input logic [4:0] m);
    @(negedge clk) begin
      ext_n = {~m[2], ~m[0]}; tmr_ovf = {m[3], m[1]}; ser_req = m[4];
    end
    @(negedge clk) begin ext_n = 2'b11; tmr_ovf = 0; ser_req = 0; end
  endtask

  task automatic pulse_reti;
    @(negedge clk) reti = 1;
    @(negedge clk) reti = 0;
  endtask

  task automatic cleanup;
    pulse_reti; pulse_reti;
    @(negedge clk) flag_clr = 5'h1f;
    @(negedge clk) flag_clr = 0;
    strobe(0);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    int w;
    logic [4:0] hi, ef;
    repeat (3) @(negedge clk);
    // R1
    chk(flags == 0, "R1 flags", int'(flags), 0);
    chk(in_svc == 0, "R1 in_svc", int'(in_svc), 0);
    chk(vec_req == 0, "R1 vec_req", int'(vec_req), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: each source sets its own bit
    for (int s = 0; s < 5; s++) begin
      raise(5'(1 << s));
      chk(flags == 5'(1 << s), "R2 flag set", int'(flags), 1 << s);
      @(negedge clk) flag_clr = 5'h1f;
      @(negedge clk) flag_clr = 0;
    end

    // R3: level mode on external 0
    ext_lvl = 2'b01;
    @(negedge clk) ext_n[0] = 0;
    @(negedge clk) flag_clr = 5'h01;
    @(negedge clk) flag_clr = 0;
    chk(flags[0] == 1, "R3 clear while low", int'(flags), 1);
    @(negedge clk) ext_n[0] = 1;
    @(negedge clk);
    chk(flags[0] == 1, "R3 latched after release", int'(flags), 1);
    @(negedge clk) flag_clr = 5'h01;
    @(negedge clk) flag_clr = 0;
    chk(flags == 0, "R3 clear while high", int'(flags), 0);

    // R9: level-mode flag survives vectoring
    src_en = 5'h1f; gen = 1; pri = 0;
    strobe(0);
    @(negedge clk) ext_n[0] = 0;
    @(negedge clk) ext_n[0] = 1;
    strobe(1); strobe(1);
    chk(vec_req == 1 && vec_addr == 16'h0003, "R9 level vector", int'(vec_addr), 3);
    chk(flags[0] == 1, "R9 level flag kept", int'(flags), 1);
    cleanup;
    ext_lvl = 2'b00;

    // R6: timing of the pulse
    raise(5'h08);
    strobe(1);
    chk(vec_req == 0, "R6 no vector after first strobe", int'(vec_req), 0);
    strobe(1);
    chk(vec_req == 1 && vec_addr == 16'h001b, "R6 vector after second strobe", int'(vec_addr), 'h1b);
    @(negedge clk);
    chk(vec_req == 0, "R6 pulse one clock", int'(vec_req), 0);
    cleanup;

    // R4: masking through src_en and gen
    src_en = 5'h1d;
    raise(5'h02);
    strobe(1); strobe(1);
    chk(vec_req == 0, "R4 src_en mask", int'(vec_req), 0);
    chk(flags == 5'h02, "R4 masked flag kept", int'(flags), 2);
    src_en = 5'h1f; gen = 0;
    strobe(1); strobe(1);
    chk(vec_req == 0, "R4 gen mask", int'(vec_req), 0);
    gen = 1;
    strobe(1);
    chk(vec_req == 1 && vec_addr == 16'h000b, "R4 unmasked vector", int'(vec_addr), 'hb);
    cleanup;

    // R7: blocked polls are not remembered
    raise(5'h02);
    strobe(1);
    strobe(0);
    chk(vec_req == 0, "R7 not last cycle", int'(vec_req), 0);
    @(negedge clk) begin cyc_end = 1; last_cyc = 1; blk_instr = 1; end
    @(negedge clk) begin cyc_end = 0; last_cyc = 0; blk_instr = 0; end
    chk(vec_req == 0, "R7 blocking instruction", int'(vec_req), 0);
    @(negedge clk) flag_clr = 5'h02;
    @(negedge clk) flag_clr = 0;
    strobe(0); strobe(1); strobe(1);
    chk(vec_req == 0 && flags == 0, "R7 not remembered", int'(vec_req), 0);
    cleanup;

    // R8 and R10: preemption and release order
    pri = 5'b00101;
    raise(5'h02);
    strobe(1); strobe(1);
    chk(vec_req == 1 && in_svc == 2'b01, "R8 low service", int'(in_svc), 1);
    raise(5'h08);
    strobe(1); strobe(1);
    chk(vec_req == 0, "R8 low blocks low", int'(vec_req), 0);
    raise(5'h04);
    strobe(1); strobe(1);
    chk(vec_req == 1 && vec_addr == 16'h0013 && in_svc == 2'b11, "R8 high preempts", int'(vec_addr), 'h13);
    raise(5'h01);
    strobe(1); strobe(1);
    chk(vec_req == 0, "R8 high blocks high", int'(vec_req), 0);
    pulse_reti;
    chk(in_svc == 2'b01, "R10 high released first", int'(in_svc), 1);
    strobe(1);
    chk(vec_req == 1 && vec_addr == 16'h0003 && in_svc == 2'b11, "R8 pending high after release", int'(vec_addr), 3);
    pulse_reti;
    pulse_reti;
    chk(in_svc == 2'b00, "R10 low released", int'(in_svc), 0);
    cleanup;

    // R11: set wins over clear
    @(negedge clk) begin tmr_ovf = 2'b01; flag_clr = 5'h02; end
    @(negedge clk) begin tmr_ovf = 0; flag_clr = 0; end
    chk(flags == 5'h02, "R11 set wins", int'(flags), 2);
    @(negedge clk) flag_clr = 5'h02;
    @(negedge clk) flag_clr = 0;
    chk(flags == 0, "R11 clear", int'(flags), 0);
    strobe(0);

    // R5 and R9: sweep all pending sets against all priority settings
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 32; p++) begin
        pri = 5'(p);
        raise(5'(m));
        strobe(1); strobe(1);
        hi = 5'(m & p);
        w = -1;
        for (int i = 4; i >= 0; i--) if (hi[i]) w = i;
        if (w < 0) for (int i = 4; i >= 0; i--) if (m[i]) w = i;
        if (w < 0) chk(vec_req == 0, "R5 idle", int'(vec_req), 0);
        else chk(vec_req == 1 && int'(vec_addr) == 3 + 8 * w, "R5 winner",
                 vec_req ? int'(vec_addr) : -1, 3 + 8 * w);
        ef = 5'(m);
        if (w >= 0 && w < 4) ef[w] = 1'b0;
        chk(flags == ef, "R9 flags after vector", int'(flags), int'(ef));
        cleanup;
      end
    end

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule